// File: doc/BRIEF.md
# Gate Transition Weight Cost Matrix Builder

This block fills a square cost matrix for a set of test vectors. The vectors drive a small combinational netlist made only of two-input NAND gates. Each entry of the matrix is the cost of applying one vector directly after another. The block evaluates every gate under both vectors to find the input pair each gate sees before and after the change. It then looks up a weight for that exact input transition and adds the weights of all gates. A transition that leaves the gate output unchanged still has a cost, because the weight depends on the inputs and not on the output.

The user loads up to `NVEC` vectors through a write port and sets up the netlist on a configuration bus. The user then gives the vector count and pulses `start`. The block visits every ordered pair, one per clock, with the row as the outer loop. Each result leaves on a registered write port that a downstream matrix memory can take directly. The diagonal gets a reserved maximum code, so an ordering engine working from the matrix never picks a vector to follow itself.

Top module: `tcm_cost_matrix`

## Requirements
- R1: After `start` is accepted with an effective count n>0, the block makes exactly n*n writes on consecutive clocks. Each write has `mw_en`=1, and the writes run in row-major order (row 0 col 0, row 0 col 1, ...). `done` is high for one clock, in the same clock as the last write, and neither `done` nor `mw_en` follows it.
- R2: For i≠j, entry [i][j] is the sum, over all gates, of the weight of the gate's input pair moving from its value under vector i to its value under vector j.
- R3: An input pair is written {A,B}, with A as the upper bit. Its weights are: 11→10 is 24, 11→00 is 23, 01→10 is 15, 11→01 is 14, 10→00 is 9, 00→01 is 8, 01→00 is 7, 10→01 is 3, 00→10 is 2, and 00→11, 01→11 and 10→11 are each 1.
- R4: A gate whose input pair is the same under both vectors adds 0.
- R5: Gate g owns bits [g*8+7 : g*8] of `net_cfg`: source A is in the upper nibble and source B in the lower nibble. A source s<8 reads bit s of the vector. A source 8≤s<8+g reads the NAND output of gate s-8 under the same vector. Any other source reads 0.
- R6: A diagonal entry [i][i] is written as 255.
- R7: An off-diagonal sum saturates at 254, so an off-diagonal entry is never 255.
- R8: A `start` with `num_vec`=0 gives a `done` pulse on the next clock and no writes. A `num_vec` above 16 is treated as 16.
- R9: A `start` that arrives while a matrix is being built is ignored and does not disturb the pair sequence.
- R10: Out of reset, `mw_en` and `done` are low.
- R11: `ld_en` stores `ld_vec` at slot `ld_idx`. The slot keeps that value until it is overwritten, and later matrices use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Vector store write enable |
| ld_idx | input | 4 | Vector slot to write |
| ld_vec | input | 8 | Vector value to store |
| net_cfg | input | 64 | NAND netlist source selects, held stable while building |
| num_vec | input | 5 | Number of vectors in the set |
| start | input | 1 | Pulse to begin building the matrix |
| done | output | 1 | One-clock pulse with the last write |
| mw_en | output | 1 | Matrix write strobe |
| mw_row | output | 4 | Row index of the entry (earlier vector) |
| mw_col | output | 4 | Column index of the entry (later vector) |
| mw_cost | output | 8 | Cost value of the entry |

## Verification
A wrong row or column counter shows up at once on the write port: a pair is skipped or repeated, or the pair order breaks on the same clock. It also changes the total write count when `done` arrives. A wrong gate source or weight shows up only in the costs of pairs whose vectors drive the faulty path differently. Random netlists and vector sets are therefore compared entry by entry against a reference model. Directed sets of identical vectors expose any nonzero weight given to an unchanged pair.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
    localparam int TCM_NVEC  = 16;
    localparam int TCM_VBITS = 8;
    localparam int TCM_NGATE = 8;
    localparam int TCM_CW    = 8;
    localparam int TCM_WW    = 5;

    // weight of one NAND input transition, pair written {A,B}
    function automatic logic [TCM_WW-1:0] nand_weight(input logic [1:0] from_p,
                                                      input logic [1:0] to_p);
        logic [TCM_WW-1:0] w;
        case ({from_p, to_p})
            4'b00_01: w = 5'd8;
            4'b00_10: w = 5'd2;
            4'b00_11: w = 5'd1;
            4'b01_00: w = 5'd7;
            4'b01_10: w = 5'd15;
            4'b01_11: w = 5'd1;
            4'b10_00: w = 5'd9;
            4'b10_01: w = 5'd3;
            4'b10_11: w = 5'd1;
            4'b11_00: w = 5'd23;
            4'b11_01: w = 5'd14;
            4'b11_10: w = 5'd24;
            default:  w = 5'd0;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/tcm_vec_store.sv
module tcm_vec_store #(
    parameter int NVEC  = 16,
    parameter int VBITS = 8,
    localparam int IDX_W = $clog2(NVEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VBITS-1:0] wr_vec,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [VBITS-1:0] rd_a_vec,
    output logic [VBITS-1:0] rd_b_vec
);
    logic [NVEC-1:0][VBITS-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = wr_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_a_vec = mem_q[rd_a_idx];
    assign rd_b_vec = mem_q[rd_b_idx];
endmodule

// File: rtl/tcm_gate_eval.sv
module tcm_gate_eval #(
    parameter int VBITS = 8,
    parameter int NGATE = 8,
    localparam int SRC_W = $clog2(VBITS + NGATE),
    localparam int VB_W  = (VBITS > 1) ? $clog2(VBITS) : 1,
    localparam int GI_W  = (NGATE > 1) ? $clog2(NGATE) : 1,
    localparam int CFG_W = NGATE * 2 * SRC_W
) (
    input  logic [VBITS-1:0]   vec,
    input  logic [CFG_W-1:0]   net_cfg,
    output logic [2*NGATE-1:0] pairs
);
    logic [NGATE-1:0] outs;

    function automatic logic pick(input logic [SRC_W-1:0] src,
                                  input logic [VBITS-1:0] v,
                                  input logic [NGATE-1:0] o,
                                  input int gate);
        int   gi;
        logic bit_v;
        bit_v = 1'b0;
        if (int'(src) < VBITS) begin
            bit_v = v[src[VB_W-1:0]];
        end else begin
            gi = int'(src) - VBITS;
            if (gi < gate) begin
                bit_v = o[gi[GI_W-1:0]];
            end
        end
        return bit_v;
    endfunction

    always_comb begin
        logic [SRC_W-1:0] sa, sb;
        logic             a, b;
        outs  = '0;
        pairs = '0;
        for (int g = 0; g < NGATE; g++) begin
            sa = net_cfg[g*2*SRC_W + SRC_W +: SRC_W];
            sb = net_cfg[g*2*SRC_W +: SRC_W];
            a  = pick(sa, vec, outs, g);
            b  = pick(sb, vec, outs, g);
            pairs[2*g +: 2] = {a, b};
            outs[g] = ~(a & b);
        end
    end
endmodule

// File: rtl/tcm_pair_cost.sv
module tcm_pair_cost
    import tcm_pkg::*;
#(
    parameter int NGATE = 8,
    parameter int CW    = 8,
    localparam int SUM_W = $clog2(NGATE * 24 + 1) + 1,
    localparam int ACC_W = (SUM_W > CW) ? SUM_W : CW + 1,
    localparam int SAT   = (1 << CW) - 2
) (
    input  logic [2*NGATE-1:0] from_pairs,
    input  logic [2*NGATE-1:0] to_pairs,
    output logic [CW-1:0]      cost
);
    logic [NGATE-1:0][TCM_WW-1:0] w;

    for (genvar g = 0; g < NGATE; g++) begin : g_wt
        assign w[g] = nand_weight(from_pairs[2*g +: 2], to_pairs[2*g +: 2]);
    end

    always_comb begin
        logic [ACC_W-1:0] acc;
        acc = '0;
        for (int g = 0; g < NGATE; g++) begin
            acc = acc + ACC_W'(w[g]);
        end
        if (acc > ACC_W'(SAT)) begin
            cost = CW'(SAT);
        end else begin
            cost = acc[CW-1:0];
        end
    end
endmodule

// File: rtl/tcm_cost_matrix.sv
module tcm_cost_matrix
    import tcm_pkg::*;
#(
    parameter int NVEC  = TCM_NVEC,
    parameter int VBITS = TCM_VBITS,
    parameter int NGATE = TCM_NGATE,
    parameter int CW    = TCM_CW,
    localparam int IDX_W = $clog2(NVEC),
    localparam int CNT_W = $clog2(NVEC + 1),
    localparam int SRC_W = $clog2(VBITS + NGATE),
    localparam int CFG_W = NGATE * 2 * SRC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [VBITS-1:0] ld_vec,
    input  logic [CFG_W-1:0] net_cfg,
    input  logic [CNT_W-1:0] num_vec,
    input  logic             start,
    output logic             done,
    output logic             mw_en,
    output logic [IDX_W-1:0] mw_row,
    output logic [IDX_W-1:0] mw_col,
    output logic [CW-1:0]    mw_cost
);
    localparam logic [CW-1:0] DIAG_CODE = '1;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] row;
        logic [IDX_W-1:0] col;
        logic [IDX_W-1:0] last;
        logic             wr;
        logic [IDX_W-1:0] wr_row;
        logic [IDX_W-1:0] wr_col;
        logic [CW-1:0]    wr_cost;
        logic             done;
    } seq_t;

    seq_t q, d;

    logic [VBITS-1:0]   vec_from, vec_to;
    logic [2*NGATE-1:0] pairs_from, pairs_to;
    logic [CW-1:0]      pair_cost;
    logic [CNT_W-1:0]   eff_n;

    tcm_vec_store #(.NVEC(NVEC), .VBITS(VBITS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ld_en),
        .wr_idx   (ld_idx),
        .wr_vec   (ld_vec),
        .rd_a_idx (q.row),
        .rd_b_idx (q.col),
        .rd_a_vec (vec_from),
        .rd_b_vec (vec_to)
    );

    tcm_gate_eval #(.VBITS(VBITS), .NGATE(NGATE)) u_eval_from (
        .vec     (vec_from),
        .net_cfg (net_cfg),
        .pairs   (pairs_from)
    );

    tcm_gate_eval #(.VBITS(VBITS), .NGATE(NGATE)) u_eval_to (
        .vec     (vec_to),
        .net_cfg (net_cfg),
        .pairs   (pairs_to)
    );

    tcm_pair_cost #(.NGATE(NGATE), .CW(CW)) u_cost (
        .from_pairs (pairs_from),
        .to_pairs   (pairs_to),
        .cost       (pair_cost)
    );

    assign eff_n = (int'(num_vec) > NVEC) ? CNT_W'(NVEC) : num_vec;

    always_comb begin
        d      = q;
        d.wr   = 1'b0;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                if (eff_n == '0) begin
                    d.done = 1'b1;
                end else begin
                    d.busy = 1'b1;
                    d.row  = '0;
                    d.col  = '0;
                    d.last = IDX_W'(eff_n - CNT_W'(1));
                end
            end
        end else begin
            d.wr      = 1'b1;
            d.wr_row  = q.row;
            d.wr_col  = q.col;
            d.wr_cost = (q.row == q.col) ? DIAG_CODE : pair_cost;
            if (q.col == q.last) begin
                d.col = '0;
                if (q.row == q.last) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.row = q.row + IDX_W'(1);
                end
            end else begin
                d.col = q.col + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done    = q.done;
    assign mw_en   = q.wr;
    assign mw_row  = q.wr_row;
    assign mw_col  = q.wr_col;
    assign mw_cost = q.wr_cost;
endmodule

// File: rtl/tcm_cost_matrix_chk.sv
module tcm_cost_matrix_chk #(
    parameter int IDX_W = 4,
    parameter int CW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             mw_en,
    input logic [IDX_W-1:0] mw_row,
    input logic [IDX_W-1:0] mw_col,
    input logic [CW-1:0]    mw_cost
);
    // R6
    p_diag_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_en && mw_row == mw_col) |-> (mw_cost == '1));

    // R7
    p_offdiag_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_en && mw_row != mw_col) |-> (mw_cost != '1));

    // R1: a build begins at the origin
    p_first_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mw_en) |-> (mw_row == '0 && mw_col == '0));

    // R1: column steps by one within a row
    p_col_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_en && mw_col != '0) |->
        ($past(mw_en) && mw_row == $past(mw_row) && mw_col == IDX_W'($past(mw_col) + 1'b1)));

    // R1: writes are contiguous until done
    p_no_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_en && !done) |=> mw_en);

    // R1: done is a single pulse with nothing after it
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !mw_en));
endmodule

bind tcm_cost_matrix tcm_cost_matrix_chk #(.IDX_W(IDX_W), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .mw_en   (mw_en),
    .mw_row  (mw_row),
    .mw_col  (mw_col),
    .mw_cost (mw_cost)
);

// File: tb/tcm_cost_matrix_tb.sv
`timescale 1ns/1ps
module tcm_cost_matrix_tb;
    localparam int NV = 16;
    localparam int NG = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [7:0]  ld_vec = '0;
    logic [63:0] net_cfg = '0;
    logic [4:0]  num_vec = '0;
    logic        start = 1'b0;
    logic        done, mw_en;
    logic [3:0]  mw_row, mw_col;
    logic [7:0]  mw_cost;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [7:0] vecs [NV];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tcm_cost_matrix u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_vec(ld_vec),
        .net_cfg(net_cfg), .num_vec(num_vec), .start(start), .done(done),
        .mw_en(mw_en), .mw_row(mw_row), .mw_col(mw_col), .mw_cost(mw_cost)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_w(input int f, input int t);
        int tbl [16] = '{0, 8, 2, 1, 7, 0, 15, 1, 9, 3, 0, 1, 23, 14, 24, 0};
        return tbl[f*4 + t];
    endfunction

    function automatic logic [15:0] m_pairs(input logic [7:0] v, input logic [63:0] cfg);
        logic [15:0] p;
        logic [7:0]  o;
        o = '0;
        p = '0;
        for (int g = 0; g < NG; g++) begin
            int s [2];
            logic ab [2];
            s[0] = int'(cfg[g*8+4 +: 4]);
            s[1] = int'(cfg[g*8 +: 4]);
            for (int k = 0; k < 2; k++) begin
                if (s[k] < 8) ab[k] = v[s[k]];
                else if (s[k] - 8 < g) ab[k] = o[s[k]-8];
                else ab[k] = 1'b0;
            end
            p[2*g +: 2] = {ab[0], ab[1]};
            o[g] = !(ab[0] && ab[1]);
        end
        return p;
    endfunction

    function automatic int m_cost(input int i, input int j);
        logic [15:0] pf, pt;
        int sum;
        if (i == j) return 255;
        pf = m_pairs(vecs[i], net_cfg);
        pt = m_pairs(vecs[j], net_cfg);
        sum = 0;
        for (int g = 0; g < NG; g++) sum += m_w(int'(pf[2*g +: 2]), int'(pt[2*g +: 2]));
        return (sum > 254) ? 254 : sum;
    endfunction

    task automatic load(input int idx, input logic [7:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 4'(idx); ld_vec = v;
        vecs[idx] = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // run one build, poke_start re-pulses start while busy (R9)
    task automatic run(input int n_req, input bit poke_start);
        int n, k, t;
        bit seen_done;
        n = (n_req > NV) ? NV : n_req;
        k = 0; t = 0; seen_done = 0;
        @(negedge clk);
        num_vec = 5'(n_req);
        start = 1'b1;
        while (!seen_done && t < 600) begin
            @(negedge clk);
            start = (poke_start && t == 4) ? 1'b1 : 1'b0;
            t++;
            if (mw_en) begin
                check(int'(mw_row) == k / (n > 0 ? n : 1) && int'(mw_col) == k % (n > 0 ? n : 1),
                      "R1 R9 pair order", int'(mw_row)*16 + int'(mw_col), (k/(n>0?n:1))*16 + k%(n>0?n:1));
                if (mw_row == mw_col)
                    check(int'(mw_cost) == 255, "R6 diagonal", int'(mw_cost), 255);
                else
                    check(int'(mw_cost) == m_cost(int'(mw_row), int'(mw_col)),
                          "R2 R3 R4 R5 R7 R11 cost", int'(mw_cost), m_cost(int'(mw_row), int'(mw_col)));
                k++;
            end
            if (done) begin
                seen_done = 1;
                check(n == 0 ? !mw_en : mw_en, "R1 R8 done with last write", int'(mw_en), n > 0 ? 1 : 0);
            end
        end
        start = 1'b0;
        check(seen_done, "R1 done seen (watchdog)", int'(seen_done), 1);
        check(k == n * n, "R1 R8 write count", k, n * n);
        if (n == 0) check(t == 1, "R8 empty done latency", t, 1);
    endtask

    function automatic logic [63:0] rand_cfg();
        logic [63:0] c;
        for (int g = 0; g < NG; g++) begin
            c[g*8+4 +: 4] = 4'($urandom_range(0, 15));
            c[g*8 +: 4]   = 4'($urandom_range(0, 15));
        end
        return c;
    endfunction

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < NV; i++) vecs[i] = '0;
        repeat (3) @(negedge clk);
        check(!mw_en && !done, "R10 outputs in reset", int'({mw_en, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mw_en && !done, "R10 outputs after reset", int'({mw_en, done}), 0);

        // R4: identical vectors, chained netlist
        for (int g = 0; g < NG; g++) net_cfg[g*8 +: 8] = {4'(g), 4'(8 + (g > 0 ? g - 1 : 0))};
        for (int i = 0; i < 4; i++) load(i, 8'hA5);
        run(4, 0);

        // R3 R5: each gate on primary input pairs, directed vectors
        for (int g = 0; g < NG; g++) net_cfg[g*8 +: 8] = {4'((2*g) % 8), 4'((2*g+1) % 8)};
        load(0, 8'h00); load(1, 8'hFF); load(2, 8'h55); load(3, 8'hAA); load(4, 8'h0F); load(5, 8'hF0);
        run(6, 0);

        // R5: random netlists including out-of-order sources
        for (int r = 0; r < 4; r++) begin
            net_cfg = rand_cfg();
            for (int i = 0; i < NV; i++) load(i, 8'($urandom));
            run((r == 3) ? 16 : $urandom_range(2, 15), 0);
        end

        // R8: single, empty and oversize counts
        run(1, 0);
        run(0, 0);
        run(20, 0);

        // R9: start while busy
        run(5, 1);

        // R11: overwrite a slot and rebuild
        load(3, ~vecs[3]);
        run(6, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule